// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block holds the configuration state that a processor core uses to steer its memory management unit and caches. The core reaches it through coprocessor move instructions. A write port takes the primary register number, the secondary register number, the sub-operation code and a 32-bit value. A read port takes the primary register number and the sub-operation code, and returns a 32-bit word one cycle later.

Each stored register applies its own masks on write. Some bits are forced to one, some are forced to zero, and some registers keep every bit. Register 0 is not storage. It returns a fixed identification word chosen by the sub-operation code. Primary registers 7 (cache maintenance) and 8 (translation-buffer maintenance) hold no state. A write to either one is passed on as a single-cycle strobe to a separate operation decoder, with the secondary register number, the sub-operation code and the data attached.

Reads and strobes come from registers. A read issued in the same cycle as a write to the same register returns the value held before that write.

Top module: `sysctl_regfile`

## Requirements
- R1: After a synchronous reset every stored register is zero, except the control register, which holds 0x00050078. Both strobes and `rd_valid` are low, and `rd_data` is zero.
- R2: The control register is primary number 1. A write to it stores (value OR 0x00050078) AND 0x0005F3FF. A read returns the stored value under the same masks.
- R3: The translation table base is primary number 2. It keeps only bits 31:14, so a write stores value AND 0xFFFFC000.
- R4: Fault status is primary number 5. It is written only when the sub-operation code is 0, and then only bits 7:0 are kept. A write with any other code leaves it unchanged. A read with a nonzero code returns zero.
- R5: The process identifier is primary number 13. A write stores value AND 0xFE000000.
- R6: Primary number 0 is read-only. Sub-operation code 0 returns the `ID_WORD` parameter. Code 1 returns the cache description 0x1D0D2112. Code 2 returns zero, the tightly-coupled memory status. Any other code returns zero.
- R7: Domain access control (primary 3), fault address (primary 6) and translation-buffer lockdown (primary 10) store and return all 32 bits unmasked.
- R8: Primary numbers 4, 7, 8, 9, 11, 12, 14 and 15 read as zero. A write to 0, 4, 9, 11, 12, 14 or 15 changes no stored register.
- R9: A write to primary 7 raises `cache_op_stb` for exactly the next cycle. A write to primary 8 raises `tlb_op_stb` for exactly the next cycle. In that cycle `op_crm`, `op_op2` and `op_data` carry the secondary number, the sub-operation code and the value of that write. A write to any other register raises neither strobe.
- R10: A read sampled with `rd_en` high at a clock edge drives `rd_data` and pulses `rd_valid` after that edge. `rd_data` holds its value while `rd_en` is low. A read issued in the same cycle as a write to the same register returns the value held before the write.

Behaviour that depends on these encodings: the primary register number is instruction bits 19:16, and the sub-operation code is instruction bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_crn | input | 4 | Primary register number of the write |
| wr_crm | input | 4 | Secondary register number of the write |
| wr_op2 | input | 3 | Sub-operation code of the write |
| wr_data | input | 32 | Write value |
| rd_en | input | 1 | Read request |
| rd_crn | input | 4 | Primary register number of the read |
| rd_op2 | input | 3 | Sub-operation code of the read |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | High for one cycle after a read request |
| cache_op_stb | output | 1 | Cache maintenance request strobe |
| tlb_op_stb | output | 1 | Translation-buffer maintenance request strobe |
| op_crm | output | 4 | Secondary register number of the forwarded operation |
| op_op2 | output | 3 | Sub-operation code of the forwarded operation |
| op_data | output | 32 | Value of the forwarded operation |

## Verification
The bench drives the control register with all ones and with all zeros.
- A design that dropped the forced-one bits would read back bits 6:3, 16 or 18 as zero.
- A design that forgot the forced-zero bits would leak bits 10 or 17 and above.

The bench writes fault status with a nonzero sub-operation code and writes an unimplemented register. A design with too loose a decode would corrupt stored state that a later read exposes.

The bench also checks:
- that each strobe lasts one cycle and lands on the right output;
- that a non-operation write raises no strobe;
- that a read and a write issued together to the same register return the old value. A design that forwarded the write would return the new value there.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN  = 32;
  localparam int CRN_W = 4;
  localparam int CRM_W = 4;
  localparam int OP2_W = 3;

  localparam logic [CRN_W-1:0] CRN_IDENT    = 4'd0;
  localparam logic [CRN_W-1:0] CRN_CTRL     = 4'd1;
  localparam logic [CRN_W-1:0] CRN_TTB      = 4'd2;
  localparam logic [CRN_W-1:0] CRN_DOM      = 4'd3;
  localparam logic [CRN_W-1:0] CRN_FSTAT    = 4'd5;
  localparam logic [CRN_W-1:0] CRN_FADDR    = 4'd6;
  localparam logic [CRN_W-1:0] CRN_CACHE_OP = 4'd7;
  localparam logic [CRN_W-1:0] CRN_TLB_OP   = 4'd8;
  localparam logic [CRN_W-1:0] CRN_TLBLOCK  = 4'd10;
  localparam logic [CRN_W-1:0] CRN_PROCID   = 4'd13;

  localparam logic [XLEN-1:0] CTRL_SET   = 32'h0005_0078;
  localparam logic [XLEN-1:0] CTRL_KEEP  = 32'h0005_F3FF;
  localparam logic [XLEN-1:0] TTB_KEEP   = 32'hFFFF_C000;
  localparam logic [XLEN-1:0] FSTAT_KEEP = 32'h0000_00FF;
  localparam logic [XLEN-1:0] PROC_KEEP  = 32'hFE00_0000;
  localparam logic [XLEN-1:0] CACHE_DESC = 32'h1D0D_2112;

  localparam int NSLOT = 7;
  typedef enum logic [2:0] {
    S_CTRL = 3'd0, S_TTB = 3'd1, S_DOM = 3'd2, S_FSTAT = 3'd3,
    S_FADDR = 3'd4, S_LOCK = 3'd5, S_PROC = 3'd6
  } slot_e;

  typedef logic [NSLOT-1:0][XLEN-1:0] slot_vec_t;
endpackage

// File: rtl/sysctl_wr_decode.sv
module sysctl_wr_decode
  import sysctl_pkg::*;
(
  input  logic             wr_en,
  input  logic [CRN_W-1:0] wr_crn,
  input  logic [OP2_W-1:0] wr_op2,
  input  logic [XLEN-1:0]  wr_data,
  output logic [NSLOT-1:0] slot_we,
  output slot_vec_t        slot_val
);
  always_comb begin
    slot_we = '0;
    if (wr_en) begin
      unique case (wr_crn)
        CRN_CTRL:    slot_we[S_CTRL]  = 1'b1;
        CRN_TTB:     slot_we[S_TTB]   = 1'b1;
        CRN_DOM:     slot_we[S_DOM]   = 1'b1;
        CRN_FSTAT:   slot_we[S_FSTAT] = (wr_op2 == '0);
        CRN_FADDR:   slot_we[S_FADDR] = 1'b1;
        CRN_TLBLOCK: slot_we[S_LOCK]  = 1'b1;
        CRN_PROCID:  slot_we[S_PROC]  = 1'b1;
        default:     slot_we = '0;
      endcase
    end
  end

  always_comb begin
    slot_val          = '0;
    slot_val[S_CTRL]  = (wr_data | CTRL_SET) & CTRL_KEEP;
    slot_val[S_TTB]   = wr_data & TTB_KEEP;
    slot_val[S_DOM]   = wr_data;
    slot_val[S_FSTAT] = wr_data & FSTAT_KEEP;
    slot_val[S_FADDR] = wr_data;
    slot_val[S_LOCK]  = wr_data;
    slot_val[S_PROC]  = wr_data & PROC_KEEP;
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] slot_we,
  input  slot_vec_t        slot_val,
  output slot_vec_t        slot_q
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [XLEN-1:0] RST_VAL = (i == int'(S_CTRL)) ? CTRL_SET : '0;
    always_ff @(posedge clk) begin
      if (rst)             slot_q[i] <= RST_VAL;
      else if (slot_we[i]) slot_q[i] <= slot_val[i];
    end
  end
endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux
  import sysctl_pkg::*;
#(
  parameter logic [XLEN-1:0] ID_WORD = 32'h4A5C_0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [CRN_W-1:0] rd_crn,
  input  logic [OP2_W-1:0] rd_op2,
  input  slot_vec_t        slot_q,
  output logic [XLEN-1:0]  rd_data,
  output logic             rd_valid
);
  logic [XLEN-1:0] sel;

  always_comb begin
    unique case (rd_crn)
      CRN_IDENT: begin
        unique case (rd_op2)
          3'd0:    sel = ID_WORD;
          3'd1:    sel = CACHE_DESC;
          default: sel = '0;
        endcase
      end
      CRN_CTRL:    sel = (slot_q[S_CTRL] | CTRL_SET) & CTRL_KEEP;
      CRN_TTB:     sel = slot_q[S_TTB];
      CRN_DOM:     sel = slot_q[S_DOM];
      CRN_FSTAT:   sel = (rd_op2 == '0) ? slot_q[S_FSTAT] : '0;
      CRN_FADDR:   sel = slot_q[S_FADDR];
      CRN_TLBLOCK: sel = slot_q[S_LOCK];
      CRN_PROCID:  sel = slot_q[S_PROC];
      default:     sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end
endmodule

// File: rtl/sysctl_op_fwd.sv
module sysctl_op_fwd
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CRN_W-1:0] wr_crn,
  input  logic [CRM_W-1:0] wr_crm,
  input  logic [OP2_W-1:0] wr_op2,
  input  logic [XLEN-1:0]  wr_data,
  output logic             cache_op_stb,
  output logic             tlb_op_stb,
  output logic [CRM_W-1:0] op_crm,
  output logic [OP2_W-1:0] op_op2,
  output logic [XLEN-1:0]  op_data
);
  logic hit_cache, hit_tlb;
  assign hit_cache = wr_en && (wr_crn == CRN_CACHE_OP);
  assign hit_tlb   = wr_en && (wr_crn == CRN_TLB_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_op_stb <= 1'b0;
      tlb_op_stb   <= 1'b0;
      op_crm       <= '0;
      op_op2       <= '0;
      op_data      <= '0;
    end else begin
      cache_op_stb <= hit_cache;
      tlb_op_stb   <= hit_tlb;
      if (hit_cache || hit_tlb) begin
        op_crm  <= wr_crm;
        op_op2  <= wr_op2;
        op_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h4A5C_0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  wr_crn,
  input  logic [3:0]  wr_crm,
  input  logic [2:0]  wr_op2,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [3:0]  rd_crn,
  input  logic [2:0]  rd_op2,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        cache_op_stb,
  output logic        tlb_op_stb,
  output logic [3:0]  op_crm,
  output logic [2:0]  op_op2,
  output logic [31:0] op_data
);
  logic [NSLOT-1:0] slot_we;
  slot_vec_t        slot_val;
  slot_vec_t        slot_q;

  sysctl_wr_decode u_dec (
    .wr_en(wr_en), .wr_crn(wr_crn), .wr_op2(wr_op2), .wr_data(wr_data),
    .slot_we(slot_we), .slot_val(slot_val)
  );

  sysctl_store u_store (
    .clk(clk), .rst(rst), .slot_we(slot_we), .slot_val(slot_val), .slot_q(slot_q)
  );

  sysctl_rd_mux #(.ID_WORD(ID_WORD)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_crn(rd_crn), .rd_op2(rd_op2),
    .slot_q(slot_q), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  sysctl_op_fwd u_fwd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_crn(wr_crn), .wr_crm(wr_crm),
    .wr_op2(wr_op2), .wr_data(wr_data), .cache_op_stb(cache_op_stb),
    .tlb_op_stb(tlb_op_stb), .op_crm(op_crm), .op_op2(op_op2), .op_data(op_data)
  );
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  wr_crn,
  input logic [3:0]  wr_crm,
  input logic [2:0]  wr_op2,
  input logic [31:0] wr_data,
  input logic        rd_en,
  input logic [3:0]  rd_crn,
  input logic [2:0]  rd_op2,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        cache_op_stb,
  input logic        tlb_op_stb,
  input logic [3:0]  op_crm,
  input logic [2:0]  op_op2,
  input logic [31:0] op_data
);
  p_ctrl_forced_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_crn) == 4'd1) |->
      ((rd_data & 32'h0005_0078) == 32'h0005_0078) && ((rd_data & ~32'h0005_F3FF) == 32'h0));

  p_ttb_low_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_crn) == 4'd2) |-> (rd_data[13:0] == 14'h0));

  p_fstat_width_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_crn) == 4'd5) |-> (rd_data[31:8] == 24'h0));

  p_proc_low_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_crn) == 4'd13) |-> (rd_data[24:0] == 25'h0));

  p_cache_desc_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_crn) == 4'd0 && $past(rd_op2) == 3'd1) |-> (rd_data == 32'h1D0D_2112));

  p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ($past(rd_crn) == 4'd4 || $past(rd_crn) == 4'd9 || $past(rd_crn) == 4'd15))
      |-> (rd_data == 32'h0));

  p_stb_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({cache_op_stb, tlb_op_stb}) <= 1);

  p_cache_src_r9: assert property (@(posedge clk) disable iff (rst)
    cache_op_stb |-> $past(wr_en && wr_crn == 4'd7));

  p_tlb_src_r9: assert property (@(posedge clk) disable iff (rst)
    tlb_op_stb |-> $past(wr_en && wr_crn == 4'd8));

  p_op_fields_r9: assert property (@(posedge clk) disable iff (rst)
    (cache_op_stb || tlb_op_stb) |->
      (op_data == $past(wr_data) && op_crm == $past(wr_crm) && op_op2 == $past(wr_op2)));

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid == $past(rd_en)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));
endmodule

bind sysctl_regfile sysctl_regfile_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_crn(wr_crn), .wr_crm(wr_crm),
  .wr_op2(wr_op2), .wr_data(wr_data), .rd_en(rd_en), .rd_crn(rd_crn),
  .rd_op2(rd_op2), .rd_data(rd_data), .rd_valid(rd_valid),
  .cache_op_stb(cache_op_stb), .tlb_op_stb(tlb_op_stb), .op_crm(op_crm),
  .op_op2(op_op2), .op_data(op_data)
);

// File: tb/sysctl_regfile_tb_top.sv
module sysctl_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_W = 32'h4A5C_0001;

  typedef struct packed {
    logic [3:0]  crn;
    logic [2:0]  op2;
    logic [31:0] wv;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 11;
  // R2 control masks, R3 base mask, R4 fault status, R5 process id, R7 unmasked
  localparam vec_t VEC [NVEC] = '{
    '{4'd1,  3'd0, 32'h0000_0000, 32'h0005_0078, 8'd2},
    '{4'd1,  3'd0, 32'hFFFF_FFFF, 32'h0005_F3FF, 8'd2},
    '{4'd1,  3'd0, 32'h0000_1005, 32'h0005_107D, 8'd2},
    '{4'd2,  3'd0, 32'h1234_5678, 32'h1234_4000, 8'd3},
    '{4'd2,  3'd0, 32'hFFFF_FFFF, 32'hFFFF_C000, 8'd3},
    '{4'd3,  3'd0, 32'hA5A5_F00F, 32'hA5A5_F00F, 8'd7},
    '{4'd5,  3'd0, 32'hDEAD_BEEF, 32'h0000_00EF, 8'd4},
    '{4'd6,  3'd0, 32'hCAFE_F00D, 32'hCAFE_F00D, 8'd7},
    '{4'd10, 3'd0, 32'h1357_2468, 32'h1357_2468, 8'd7},
    '{4'd13, 3'd0, 32'hFFFF_FFFF, 32'hFE00_0000, 8'd5},
    '{4'd13, 3'd0, 32'h03FF_FFFF, 32'h0200_0000, 8'd5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_crn = '0;
  logic [3:0]  wr_crm = '0;
  logic [2:0]  wr_op2 = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_crn = '0;
  logic [2:0]  rd_op2 = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        cache_op_stb, tlb_op_stb;
  logic [3:0]  op_crm;
  logic [2:0]  op_op2;
  logic [31:0] op_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regfile #(.ID_WORD(ID_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_crn(wr_crn), .wr_crm(wr_crm),
    .wr_op2(wr_op2), .wr_data(wr_data), .rd_en(rd_en), .rd_crn(rd_crn),
    .rd_op2(rd_op2), .rd_data(rd_data), .rd_valid(rd_valid),
    .cache_op_stb(cache_op_stb), .tlb_op_stb(tlb_op_stb), .op_crm(op_crm),
    .op_op2(op_op2), .op_data(op_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] crn, input logic [3:0] crm,
                          input logic [2:0] op2, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_crn = crn; wr_crm = crm; wr_op2 = op2; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] crn, input logic [2:0] op2, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_crn = crn; rd_op2 = op2;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 strobes", {30'h0, cache_op_stb, tlb_op_stb}, 32'h0);
    check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
    do_read(4'd1, 3'd0, v);  check("R1 ctrl", v, 32'h0005_0078);
    do_read(4'd2, 3'd0, v);  check("R1 ttb", v, 32'h0);
    do_read(4'd13, 3'd0, v); check("R1 pid", v, 32'h0);
    do_read(4'd6, 3'd0, v);  check("R1 far", v, 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i].crn, 4'd0, VEC[i].op2, VEC[i].wv);
      check($sformatf("R%0d nostb", VEC[i].req), {30'h0, cache_op_stb, tlb_op_stb}, 32'h0);
      do_read(VEC[i].crn, VEC[i].op2, v);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].exp);
    end

    // R6 identification words
    do_read(4'd0, 3'd0, v); check("R6 id", v, ID_W);
    do_read(4'd0, 3'd1, v); check("R6 cache desc", v, 32'h1D0D_2112);
    do_read(4'd0, 3'd2, v); check("R6 tcm", v, 32'h0);
    do_read(4'd0, 3'd5, v); check("R6 other", v, 32'h0);

    // R4 nonzero op2 write ignored, read returns zero
    do_write(4'd5, 4'd0, 3'd1, 32'h0000_0011);
    do_read(4'd5, 3'd0, v); check("R4 op2 write ignored", v, 32'h0000_00EF);
    do_read(4'd5, 3'd1, v); check("R4 op2 read zero", v, 32'h0);

    // R8 unimplemented registers
    do_write(4'd4, 4'd0, 3'd0, 32'hFFFF_FFFF);
    do_write(4'd0, 4'd0, 3'd0, 32'hFFFF_FFFF);
    do_write(4'd15, 4'd0, 3'd0, 32'hFFFF_FFFF);
    do_read(4'd4, 3'd0, v);  check("R8 crn4", v, 32'h0);
    do_read(4'd9, 3'd0, v);  check("R8 crn9", v, 32'h0);
    do_read(4'd7, 3'd0, v);  check("R8 crn7", v, 32'h0);
    do_read(4'd3, 3'd0, v);  check("R8 dac untouched", v, 32'hA5A5_F00F);
    do_read(4'd0, 3'd0, v);  check("R8 id untouched", v, ID_W);
    do_read(4'd13, 3'd0, v); check("R8 pid untouched", v, 32'h0200_0000);

    // R9 cache strobe
    @(negedge clk);
    wr_en = 1'b1; wr_crn = 4'd7; wr_crm = 4'd5; wr_op2 = 3'd1; wr_data = 32'h8000_1234;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 cache stb", {30'h0, cache_op_stb, tlb_op_stb}, 32'h2);
    check("R9 crm", {28'h0, op_crm}, 32'h5);
    check("R9 op2", {29'h0, op_op2}, 32'h1);
    check("R9 data", op_data, 32'h8000_1234);
    @(negedge clk);
    check("R9 cache stb one cycle", {30'h0, cache_op_stb, tlb_op_stb}, 32'h0);

    // R9 translation-buffer strobe
    @(negedge clk);
    wr_en = 1'b1; wr_crn = 4'd8; wr_crm = 4'd7; wr_op2 = 3'd0; wr_data = 32'h0BAD_F00D;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 tlb stb", {30'h0, cache_op_stb, tlb_op_stb}, 32'h1);
    check("R9 tlb crm", {28'h0, op_crm}, 32'h7);
    check("R9 tlb data", op_data, 32'h0BAD_F00D);
    @(negedge clk);
    check("R9 tlb stb one cycle", {30'h0, cache_op_stb, tlb_op_stb}, 32'h0);

    // R10 same-cycle read and write return old value
    @(negedge clk);
    wr_en = 1'b1; wr_crn = 4'd3; wr_data = 32'h1111_2222; wr_op2 = 3'd0;
    rd_en = 1'b1; rd_crn = 4'd3; rd_op2 = 3'd0;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R10 old value", rd_data, 32'hA5A5_F00F);
    check("R10 valid pulse", {31'h0, rd_valid}, 32'h1);
    @(negedge clk);
    check("R10 valid drops", {31'h0, rd_valid}, 32'h0);
    check("R10 hold", rd_data, 32'hA5A5_F00F);
    do_read(4'd3, 3'd0, v); check("R10 new value", v, 32'h1111_2222);

    // R1 reset again after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_read(4'd3, 3'd0, v); check("R1 dac after reset", v, 32'h0);
    do_read(4'd1, 3'd0, v); check("R1 ctrl after reset", v, 32'h0005_0078);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule